// File: doc/BRIEF.md
# Dual-Edge Programmable Clock Divider

This block derives a pixel clock from an oscillator input. The output has a low time and a high time that are set on their own, each as a number of oscillator edges. Rising and falling oscillator edges both advance the count, so a phase can last any whole number of half oscillator periods and the duty cycle can be set freely. A system clock that runs faster than the oscillator watches it. A two-stage synchronizer and one compare flop turn every change of level into a one-cycle tick.

A small state machine runs the output. It has three states. `PH_IDLE` means no clock is being generated and the output is low. `PH_LOW` is the low phase and `PH_HIGH` is the high phase. The transitions are:

- Start: `PH_IDLE` goes to `PH_LOW` when both count inputs are nonzero.
- Rise: `PH_LOW` goes to `PH_HIGH` when the low phase ends.
- Fall: `PH_HIGH` goes to `PH_LOW` when the high phase ends.
- Halt: either phase goes to `PH_IDLE` when it ends and a count input reads zero.

The length of a phase is latched when the phase is entered. A count input can therefore change at any time, and the new value only affects a phase that starts later. The useful range of each count is 2 to 15. The count inputs have no reset value of their own.

Top module: `osc_edge_divider`

## Requirements
- R1: While `rst_n` is low and in the cycles after it rises, `pix_clk` is 0 and the machine is in `PH_IDLE`.
- R2: Each low phase of `pix_clk` lasts exactly the number of oscillator edges given by `low_count`. Rising and falling edges each count as one.
- R3: Each high phase of `pix_clk` lasts exactly the number of oscillator edges given by `high_count`. It never exceeds 15 edges.
- R4: With `low_count` = 4 and `high_count` = 4, one `pix_clk` period spans 8 oscillator edges, which is one quarter of the oscillator frequency.
- R5: A phase uses the count value present on the cycle it is entered. A write made during a phase takes effect at the next phase of that kind.
- R6: If either count reads 0 when a phase ends, the machine enters `PH_IDLE` and `pix_clk` stays low. It does not rise while either count is 0.
- R7: Once both counts are nonzero again, generation resumes from `PH_LOW` with the phase lengths correct.
- R8: A `pix_clk` transition is registered on the third rising system clock edge after the oscillator change that ends the phase. It never changes in a cycle without a detected oscillator edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Oscillator input, both edges counted |
| low_count | input | 4 | Low phase length in oscillator edges (0 halts) |
| high_count | input | 4 | High phase length in oscillator edges (0 halts) |
| pix_clk | output | 1 | Divided pixel clock |

## Verification
A corrupted phase counter or latched target is visible right away. The phase that follows comes out one or more oscillator edges too long or too short, and the next `pix_clk` transition shows it. A wrong state shows up as an output edge with no oscillator edge three cycles earlier, or as a rise while a count is zero. The delay through the synchronizer is fixed, so every transition can be checked against the exact oscillator edge that should have caused it.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/osc_edge_sense.sv
// Synchronizes the oscillator and emits a one-cycle tick on either edge.
module osc_edge_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= osc_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // The newest synchronized level is compared with the one before it.
    assign tick = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];
endmodule

// File: rtl/phase_counter.sv
// Counts ticks within one phase against a target latched at phase entry.
module phase_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    input  logic             tick,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;
    // The tick that brings the count up to the target closes the phase.
    assign done    = en && tick && (cnt_inc >= target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            target <= '0;
        end else if (load) begin
            cnt    <= '0;
            target <= load_val;
        end else if (en && tick) begin
            cnt    <= cnt_inc;
        end
    end
endmodule

// File: rtl/osc_edge_divider.sv
module osc_edge_divider #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_in,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    output logic             pix_clk
);
    import pixdiv_pkg::*;

    phase_e           state_q, state_d;
    logic             tick;
    logic             phase_done;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             counts_ok;

    osc_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .tick   (tick)
    );

    phase_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .en       (state_q != PH_IDLE),
        .tick     (tick),
        .done     (phase_done)
    );

    assign counts_ok = (low_count != '0) && (high_count != '0);

    // Next state, plus loading the length of the phase being entered.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = low_count;
        unique case (state_q)
            PH_IDLE: begin
                if (counts_ok) begin
                    state_d = PH_LOW;
                    load    = 1'b1;
                end
            end
            PH_LOW: begin
                if (phase_done) begin
                    if (counts_ok) begin
                        state_d  = PH_HIGH;
                        load     = 1'b1;
                        load_val = high_count;
                    end else begin
                        state_d  = PH_IDLE;
                    end
                end
            end
            PH_HIGH: begin
                if (phase_done) begin
                    if (counts_ok) begin
                        state_d = PH_LOW;
                        load    = 1'b1;
                    end else begin
                        state_d = PH_IDLE;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Registered output, updated on the same edge as the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_clk <= 1'b0;
        else        pix_clk <= (state_d == PH_HIGH);
    end
endmodule

// File: rtl/osc_divider_checker.sv
module osc_divider_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_in,
    input logic [CNT_W-1:0] low_count,
    input logic [CNT_W-1:0] high_count,
    input logic             pix_clk
);
    localparam int MAX_LEN = (1 << CNT_W) - 1;

    logic osc_d1, osc_d2, osc_d3;
    logic edge_seen;
    logic [CNT_W:0] hi_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_d1 <= 1'b0;
            osc_d2 <= 1'b0;
            osc_d3 <= 1'b0;
        end else begin
            osc_d1 <= osc_in;
            osc_d2 <= osc_d1;
            osc_d3 <= osc_d2;
        end
    end

    assign edge_seen = osc_d2 ^ osc_d3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_ticks <= '0;
        else if (!pix_clk)  hi_ticks <= '0;
        else if (edge_seen) hi_ticks <= hi_ticks + 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_low: assert (pix_clk == 1'b0)
                else $error("pix_clk high during reset");
        end
    end

    a_r8_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_clk != $past(pix_clk)) |-> $past(edge_seen))
        else $error("pix_clk moved without an oscillator edge");

    a_r6_no_rise_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk) |-> ($past(low_count) != '0 && $past(high_count) != '0))
        else $error("pix_clk rose while a count was zero");

    a_r3_high_limit: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ticks <= MAX_LEN)
        else $error("high phase overran");
endmodule

bind osc_edge_divider osc_divider_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/osc_edge_divider_bench.sv
module osc_edge_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0;
    logic [3:0] low_count = 4'd3;
    logic [3:0] high_count = 4'd5;
    logic       pix_clk;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    int  arr = 0;
    int  arr_mark = 0;
    bit  hist0 = 0, hist1 = 0, hist2 = 0;
    bit  prev_pix = 0;
    bit  skip = 1;
    int  exp_len = 0;
    int  last_low = 0, last_high = 0;
    int  rises = 0, edges = 0;
    bit  arrived = 0;

    always #2.5 clk = ~clk;

    osc_edge_divider u_osc_edge_divider (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in),
        .low_count(low_count), .high_count(high_count), .pix_clk(pix_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int phase_len(input bit high_ph, input logic [3:0] lo, input logic [3:0] hi);
        return high_ph ? int'(hi) : int'(lo);
    endfunction

    // One system cycle: account arrived edges, observe output, maybe toggle.
    task automatic step(input bit tog);
        int len;
        @(negedge clk);
        arrived = hist2;
        arr += int'(hist2);
        hist2 = hist1;
        hist1 = hist0;
        if (pix_clk != prev_pix) begin
            len = arr - arr_mark;
            arr_mark = arr;
            edges++;
            check(arrived == 1'b1, "R8", int'(arrived), 1);
            if (pix_clk) begin
                rises++;
                last_low = len;
                if (!skip) check(len == exp_len, "R2", len, exp_len);
            end else begin
                last_high = len;
                if (!skip) check(len == exp_len, "R3", len, exp_len);
            end
            skip = 0;
            exp_len = phase_len(pix_clk, low_count, high_count);
            prev_pix = pix_clk;
        end
        if (tog) osc_in = ~osc_in;
        hist0 = tog;
    endtask

    function automatic logic [3:0] rnd_cnt();
        return 4'(2 + ($urandom % 14));
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(pix_clk == 1'b0, "R1", int'(pix_clk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_clk == 1'b0, "R1", int'(pix_clk), 0);
        exp_len = int'(low_count);

        // R2 R3: fixed counts, every cycle a toggle (back-to-back ticks).
        for (int i = 0; i < 200; i++) step(1'b1);
        // R4: quarter frequency.
        low_count = 4'd4; high_count = 4'd4;
        for (int i = 0; i < 200; i++) step(($urandom % 2) == 0);
        check(last_low + last_high == 8, "R4", last_low + last_high, 8);
        check(last_low == 4, "R4", last_low, 4);

        // R5: random writes at any cycle, random oscillator spacing.
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 3) != 0);
            if (($urandom % 23) == 0) low_count = rnd_cnt();
            if (($urandom % 29) == 0) high_count = rnd_cnt();
        end
        check(edges > 100, "R5", edges, 100);

        // Boundary lengths 2 and 15.
        low_count = 4'd2; high_count = 4'd15;
        for (int i = 0; i < 400; i++) step(1'b1);
        check(last_low == 2 && last_high == 15, "R3", last_high, 15);

        // R6: zero low count halts after the phase in progress.
        low_count = 4'd0;
        for (int i = 0; i < 80; i++) step(1'b1);
        rises = 0;
        for (int i = 0; i < 300; i++) step(($urandom % 2) == 0);
        check(rises == 0, "R6", rises, 0);
        check(pix_clk == 1'b0, "R6", int'(pix_clk), 0);

        // R7: resume.
        low_count = 4'd3; high_count = 4'd6; skip = 1;
        for (int i = 0; i < 400; i++) step(1'b1);
        check(rises > 5, "R7", rises, 6);
        check(last_low == 3 && last_high == 6, "R7", last_low, 3);

        // R6: zero high count while running, halts.
        high_count = 4'd0;
        for (int i = 0; i < 80; i++) step(1'b1);
        rises = 0;
        for (int i = 0; i < 200; i++) step(1'b1);
        check(rises == 0 && pix_clk == 1'b0, "R6", rises, 0);
        high_count = 4'd7; skip = 1;
        for (int i = 0; i < 300; i++) step(($urandom % 3) != 0);
        check(last_high == 7, "R7", last_high, 7);

        // R1: reset again mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        check(pix_clk == 1'b0, "R1", int'(pix_clk), 0);

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule